// File: doc/BRIEF.md
# Bidirectional GPIO Port Controller

This block controls one port of general-purpose pins, eight by default. Each pin has three bits spread over three byte-wide registers. A direction bit chooses whether the pin drives or listens. An output bit gives the level the pin drives, or, on an input pin, turns on its pull-up. An input bit carries the synchronized pad level back to the bus. The block drives output-enable, output-data and pull-up-enable signals toward the pad cells and takes the resolved pad level back in.

Software reaches the registers over a small internal bus. The bus has a two-bit address, a write strobe and a read strobe. Every access completes in the cycle it is presented, so there is no back-pressure and no handshake. A chip-wide pull-up disable forces every pull-up off. A sleep input stops pad levels from propagating into the input register. Writing ones to the input register's address flips the matching output bits, which lets software toggle pins without a read-modify-write.

Top module: `gpio_port`

## Requirements
- R1: An active-low reset clears the direction and output registers asynchronously. `pad_oe`, `pad_out` and `pad_pu` go to zero as soon as `rst_n` falls, even while the clock is stopped.
- R2: A write to address 1 loads the direction register on the next rising clock edge. `pad_oe` bit i equals direction bit i, where 1 means output. A read of address 1 returns the register.
- R3: A write to address 2 loads the output register on the next rising clock edge. `pad_out` equals that register, and a read of address 2 returns it.
- R4: `pad_pu` bit i is high exactly when direction bit i is 0, output bit i is 1 and `pud` is low.
- R5: While `pud` is high, every bit of `pad_pu` is 0, whatever the register contents.
- R6: A read of address 0 returns the pad level through a two-stage synchronizer. A pad change made before rising edge k shows up on reads after edge k+1.
- R7: A write to address 0 inverts each output bit whose write-data bit is 1 and leaves the others unchanged.
- R8: While `sleep` is high, a read of address 0 returns 0 and both synchronizer stages load 0. After `sleep` falls, the pad level shows up again two edges later.
- R9: `rdata` is combinational. It is 0 when `rd_en` is low or when the address is 3. A write to address 3 changes nothing.
- R10: A write to address 0 leaves the direction register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | I/O clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register select: 0 input, 1 direction, 2 output |
| wdata | input | W | Write data |
| rdata | output | W | Read data, combinational |
| pud | input | 1 | Global pull-up disable |
| sleep | input | 1 | Gates the pad input path |
| pad_in | input | W | Resolved pad levels |
| pad_oe | output | W | Per-pin driver enable |
| pad_out | output | W | Per-pin drive level |
| pad_pu | output | W | Per-pin pull-up enable |

## Verification
The bench moves a pad one edge before two consecutive reads. A synchronizer that is one stage short, or one stage too long, returns the wrong one of the two values. The toggle write is checked on a mix of ones and zeros and then the direction register is read back. A toggle done as a plain load, or one that also reaches the direction register, shows up there. The reset check stops the clock before pulling reset low, so a reset that needs a clock edge leaves the drivers enabled. Sleep is raised and dropped around input reads: a design that keeps stale synchronizer contents returns a pad value one edge too early after wake-up.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_DIR  = 2'd1,
    SEL_OUT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  reg_sel_e     sel,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] out_q
);
  // direction and output bits, cleared without a clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_DIR: dir_q <= wdata;
        SEL_OUT: out_q <= wdata;
        SEL_PIN: out_q <= out_q ^ wdata;  // toggle on ones
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sleep,
  input  logic [W-1:0] pad_in,
  output logic [W-1:0] pin_val
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  // two stages; sleep flushes both to zero
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else if (sleep) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pad_in;
      sync_q <= meta_q;
    end
  end

  assign pin_val = sleep ? '0 : sync_q;
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl #(
  parameter int W = 8
) (
  input  logic [W-1:0] dir_q,
  input  logic [W-1:0] out_q,
  input  logic         pud,
  output logic [W-1:0] pad_oe,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_pu
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    assign pad_oe[i]  = dir_q[i];
    assign pad_out[i] = out_q[i];
    assign pad_pu[i]  = ~dir_q[i] & out_q[i] & ~pud;
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  output logic [W-1:0]      rdata,
  input  logic              pud,
  input  logic              sleep,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_oe,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_pu
);
  reg_sel_e     sel;
  logic [W-1:0] dir_q;
  logic [W-1:0] out_q;
  logic [W-1:0] pin_val;

  assign sel = reg_sel_e'(addr);

  gpio_cfg_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_en),
    .sel   (sel),
    .wdata (wdata),
    .dir_q (dir_q),
    .out_q (out_q)
  );

  gpio_in_sync #(.W(W)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sleep   (sleep),
    .pad_in  (pad_in),
    .pin_val (pin_val)
  );

  gpio_pad_ctl #(.W(W)) u_pad (
    .dir_q   (dir_q),
    .out_q   (out_q),
    .pud     (pud),
    .pad_oe  (pad_oe),
    .pad_out (pad_out),
    .pad_pu  (pad_pu)
  );

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (sel)
        SEL_PIN: rdata = pin_val;
        SEL_DIR: rdata = dir_q;
        SEL_OUT: rdata = out_q;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
  import gpio_port_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [W-1:0]      wdata,
  input logic [W-1:0]      rdata,
  input logic              pud,
  input logic              sleep,
  input logic [W-1:0]      pad_in,
  input logic [W-1:0]      pad_oe,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_pu
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  // R4
  pu_vs_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0);

  // R5
  pud_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pud |-> pad_pu == '0);

  // R2
  dir_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_DIR) |=> pad_oe == $past(wdata));

  // R7
  toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_PIN) |=> pad_out == ($past(pad_out) ^ $past(wdata)));

  // R10
  toggle_keeps_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == SEL_PIN) |=> pad_oe == $past(pad_oe));

  // R8
  sleep_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sleep && rd_en && addr == SEL_PIN) |-> rdata == '0);

  // R6
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst >= 2'd2 && rd_en && addr == SEL_PIN && !sleep
     && !$past(sleep) && !$past(sleep, 2)) |-> rdata == $past(pad_in, 2));

  // R9
  idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_en || addr == SEL_NONE) |-> rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wdata   (wdata),
  .rdata   (rdata),
  .pud     (pud),
  .sleep   (sleep),
  .pad_in  (pad_in),
  .pad_oe  (pad_oe),
  .pad_out (pad_out),
  .pad_pu  (pad_pu)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  logic       clk = 1'b0;
  logic       clk_run = 1'b1;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       pud = 1'b0;
  logic       sleep = 1'b0;
  logic [7:0] ext_drv = 8'h00;
  logic [7:0] ext_val = 8'h00;
  logic [7:0] rdata, pad_oe, pad_out, pad_pu;
  wire  [7:0] pad_in;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  // pad resolution: own driver, else external driver, else pull-up, else low
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_drv & ext_val)
                | (~pad_oe & ~ext_drv & pad_pu);

  always begin
    #2.5;
    if (clk_run) clk = ~clk;
  end

  gpio_port #(.W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pud(pud), .sleep(sleep), .pad_in(pad_in),
    .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver: present a read and queue its expected value
  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b1; addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic settle();
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    #1;
  endtask

  // monitor: compare each read as the design answers it
  always @(negedge clk) begin : mon
    logic [7:0] e;
    string t;
    #1.5;
    if (rd_en) begin
      if (exp_q.size() == 0) begin
        chk("read with empty scoreboard", rdata, 8'hxx);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rdata, e);
      end
    end
  end

  initial begin
    #100000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk("R1 reset oe", pad_oe, 8'h00);
    chk("R1 reset out", pad_out, 8'h00);
    chk("R1 reset pu", pad_pu, 8'h00);
    rst_n = 1'b1;
    rd(2'd1, 8'h00, "R2 dir after reset");
    rd(2'd2, 8'h00, "R3 out after reset");
    rd(2'd0, 8'h00, "R6 pins idle");

    wr(2'd1, 8'h0F);
    chk("R2 oe follows dir", pad_oe, 8'h0F);
    rd(2'd1, 8'h0F, "R2 dir readback");
    wr(2'd2, 8'hA5);
    chk("R3 pad_out", pad_out, 8'hA5);
    chk("R4 pull-up on inputs with one", pad_pu, 8'hA0);
    rd(2'd2, 8'hA5, "R3 out readback");

    settle();
    pud = 1'b1; #1;
    chk("R5 pud forces pull-ups off", pad_pu, 8'h00);
    pud = 1'b0; #1;
    chk("R5 pud released", pad_pu, 8'hA0);

    ext_drv = 8'hF0; ext_val = 8'h30;
    repeat (3) settle();
    rd(2'd0, 8'h35, "R6 pin read steady");
    settle();
    ext_val = 8'hC0;
    rd(2'd0, 8'h35, "R6 one edge after change");
    rd(2'd0, 8'hC5, "R6 two edges after change");

    wr(2'd0, 8'h0F);
    chk("R7 toggle pad_out", pad_out, 8'hAA);
    rd(2'd2, 8'hAA, "R7 toggled out readback");
    rd(2'd1, 8'h0F, "R10 dir kept on toggle");

    settle();
    sleep = 1'b1;
    rd(2'd0, 8'h00, "R8 read in sleep");
    sleep = 1'b0;
    rd(2'd0, 8'h00, "R8 one edge after wake");
    rd(2'd0, 8'hCA, "R8 two edges after wake");

    rd(2'd3, 8'h00, "R9 unused address reads zero");
    wr(2'd3, 8'hFF);
    rd(2'd1, 8'h0F, "R9 dir after unused write");
    rd(2'd2, 8'hAA, "R9 out after unused write");
    settle();
    chk("R9 rdata with no read", rdata, 8'h00);

    wr(2'd1, 8'h00);
    chk("R4 pull-ups with all inputs", pad_pu, 8'hAA);
    chk("R2 oe cleared", pad_oe, 8'h00);
    repeat (3) settle();
    rd(2'd0, 8'hCA, "R6 pulled and driven pads");

    settle();
    wr(2'd1, 8'h3C);
    settle();
    clk_run = 1'b0;
    #3;
    rst_n = 1'b0;
    #1;
    chk("R1 async oe", pad_oe, 8'h00);
    chk("R1 async out", pad_out, 8'h00);
    chk("R1 async pu", pad_pu, 8'h00);
    clk_run = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    rd(2'd2, 8'h00, "R1 out cleared by reset");
    settle();
    settle();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule